// File: doc/BRIEF.md
# Message Interrupt Source Router

This block gathers interrupt events from a bank of 32 message buffers and from two protocol channels. It steers each event to one of eight programmable interrupt nodes. The nodes are then folded onto two active-low interrupt pins. Each message buffer raises two events, one for a received frame and one for a sent frame. Each channel raises four global events: a frame moved successfully, the last-error code was updated, the error count passed its limit, and the frame counter ticked. All events arrive as single-cycle pulses. Together these give 72 sources.

Every source holds a sticky pending flag, an enable (mask) bit and a 3-bit node number. Every node has one bit that picks the pin it drives. Software programs all of these through a small write port and clears pending flags through the same port. A pin is low while any enabled, pending source reaches it through its node.

Each access on the write port carries an operation code, a source index and a data byte. One access programs the node of one source, the mask of one source, the pending clear of one source, or the whole node-to-pin map.

Top module: `irq_router`

## Requirements
- R1: While reset is asserted, and after it is released with no further activity, both pins read high (2'b11). All pending flags are clear, all masks are closed, every source is on node 0, and every node maps to pin 0.
- R2: Source numbers are fixed as follows. The receive event of buffer b is source 2b and its transmit event is source 2b+1. Global event k (0 transfer-OK, 1 error-code update, 2 error limit, 3 frame counter) of channel c is source 64+4c+k, and it enters on globEvt bit 4c+k.
- R3: A pending flag is set by its event pulse. It stays set after the pulse ends, until it is cleared.
- R4: A write with wrOp=2 and wrData bit 0 set clears the pending flag of source wrIdx. With wrData bit 0 at zero, the write has no effect.
- R5: If a clear and a new event for the same source fall in the same cycle, the pending flag stays set.
- R6: A write with wrOp=1 sets the mask of source wrIdx to wrData bit 0, where 1 means enabled. A disabled source never drives a pin, but its pending flag is kept. Enabling it later makes it drive the pin.
- R7: A write with wrOp=0 assigns source wrIdx to node wrData[2:0].
- R8: A write with wrOp=3 loads the node-to-pin map from wrData[7:0]. If bit n is 1, node n drives intOutN[1]. If bit n is 0, node n drives intOutN[0].
- R9: Each pin is the active-low OR of all nodes mapped to it. It is registered, so an event or write sampled at a clock edge is visible on the pins right after that same edge.
- R10: A write to a source index of 72 or above, with wrOp 0, 1 or 2, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the configuration port |
| wrOp | input | 2 | Operation: 0 node, 1 mask, 2 clear, 3 pin map |
| wrIdx | input | 7 | Source index for operations 0 to 2 |
| wrData | input | 8 | Write data |
| rxEvt | input | 32 | Receive event pulses, one per buffer |
| txEvt | input | 32 | Transmit event pulses, one per buffer |
| globEvt | input | 8 | Global event pulses, bit 4c+k for channel c, event k |
| intOutN | output | 2 | Active-low interrupt pins |

## Verification
The checker covers the rules that can be seen every cycle at the pins:
- pins are idle out of reset;
- pins hold steady when no event or write arrives;
- an event can only pull a pin low, never release it;
- a zero-data clear leaves the pins alone;
- a write to an out-of-range index leaves the pins alone.

Only the bench scenarios can show the rest: source numbering, node assignment and pin mapping, and mask retention. They also show the clear-versus-event collision and the OR of several sources on one pin. The bench checks these against its own model of pending, mask, node and map state.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  parameter int NUM_BUF       = 32;
  parameter int NUM_CHAN      = 2;
  parameter int GLOB_PER_CHAN = 4;
  parameter int NUM_NODE      = 8;
  parameter int NUM_PIN       = 2;

  localparam int NUM_MSG_SRC  = 2 * NUM_BUF;
  localparam int NUM_GLOB_SRC = NUM_CHAN * GLOB_PER_CHAN;
  localparam int NUM_SRC      = NUM_MSG_SRC + NUM_GLOB_SRC;
  localparam int NODE_W       = $clog2(NUM_NODE);
  localparam int IDX_W        = $clog2(NUM_SRC);
  localparam int DATA_W       = NUM_NODE;
  localparam int PIN_W        = $clog2(NUM_PIN);

  typedef enum logic [1:0] {
    OP_NODE   = 2'd0,
    OP_MASK   = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_PINMAP = 2'd3
  } regOp_t;

  typedef struct packed {
    logic              nodeWr;
    logic              maskWr;
    logic              clrWr;
    logic              mapWr;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } cfgStrobe_t;
endpackage

// File: rtl/irqr_ctrl.sv
module irqr_ctrl
  import irq_router_pkg::*;
(
  input  logic              wrEn,
  input  logic [1:0]        wrOp,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  output cfgStrobe_t        strb
);
  regOp_t opCode;
  logic   idxOk;

  assign opCode = regOp_t'(wrOp);
  assign idxOk  = (wrIdx < IDX_W'(NUM_SRC));

  always_comb begin
    strb        = '0;
    strb.idx    = wrIdx;
    strb.data   = wrData;
    strb.nodeWr = wrEn && idxOk && (opCode == OP_NODE);
    strb.maskWr = wrEn && idxOk && (opCode == OP_MASK);
    // clear acts only when the written bit is one
    strb.clrWr  = wrEn && idxOk && (opCode == OP_CLEAR) && wrData[0];
    strb.mapWr  = wrEn && (opCode == OP_PINMAP);
  end
endmodule

// File: rtl/irqr_datapath.sv
module irqr_datapath
  import irq_router_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strb,
  input  logic [NUM_BUF-1:0] rxEvt,
  input  logic [NUM_BUF-1:0] txEvt,
  input  logic [NUM_GLOB_SRC-1:0] globEvt,
  output logic [NUM_PIN-1:0] intOutN
);
  logic [NUM_SRC-1:0]  srcEvt;
  logic [NUM_SRC-1:0]  pendQ, pendD;
  logic [NUM_SRC-1:0]  maskQ, maskD;
  logic [NODE_W-1:0]   nodeQ [NUM_SRC];
  logic [NODE_W-1:0]   nodeD [NUM_SRC];
  logic [NUM_NODE-1:0] mapQ, mapD;
  logic [NUM_NODE-1:0] nodeAct;
  logic [NUM_PIN-1:0]  pinAny;

  // fixed source layout: buffer pairs first, then channel globals
  generate
    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
      assign srcEvt[2*b]   = rxEvt[b];
      assign srcEvt[2*b+1] = txEvt[b];
    end
    for (genvar g = 0; g < NUM_GLOB_SRC; g++) begin : g_glob
      assign srcEvt[NUM_MSG_SRC+g] = globEvt[g];
    end
  endgenerate

  // per-source next state
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic hit;
      assign hit      = (strb.idx == IDX_W'(i));
      assign pendD[i] = srcEvt[i] | (pendQ[i] & ~(strb.clrWr & hit));
      assign maskD[i] = (strb.maskWr && hit) ? strb.data[0] : maskQ[i];
      assign nodeD[i] = (strb.nodeWr && hit) ? strb.data[NODE_W-1:0] : nodeQ[i];
    end
  endgenerate

  assign mapD = strb.mapWr ? strb.data[NUM_NODE-1:0] : mapQ;

  // node activity from next state, so the pin follows in the same edge
  always_comb begin
    nodeAct = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pendD[i] && maskD[i]) nodeAct[nodeD[i]] = 1'b1;
    end
  end

  always_comb begin
    pinAny = '0;
    for (int n = 0; n < NUM_NODE; n++) begin
      if (nodeAct[n]) pinAny[PIN_W'(mapD[n])] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ   <= '0;
      maskQ   <= '0;
      mapQ    <= '0;
      intOutN <= '1;
      for (int i = 0; i < NUM_SRC; i++) nodeQ[i] <= '0;
    end else begin
      pendQ   <= pendD;
      maskQ   <= maskD;
      mapQ    <= mapD;
      intOutN <= ~pinAny;
      for (int i = 0; i < NUM_SRC; i++) nodeQ[i] <= nodeD[i];
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [1:0]              wrOp,
  input  logic [IDX_W-1:0]        wrIdx,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [NUM_BUF-1:0]      rxEvt,
  input  logic [NUM_BUF-1:0]      txEvt,
  input  logic [NUM_GLOB_SRC-1:0] globEvt,
  output logic [NUM_PIN-1:0]      intOutN
);
  cfgStrobe_t strb;

  irqr_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrOp   (wrOp),
    .wrIdx  (wrIdx),
    .wrData (wrData),
    .strb   (strb)
  );

  irqr_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rxEvt   (rxEvt),
    .txEvt   (txEvt),
    .globEvt (globEvt),
    .intOutN (intOutN)
  );
endmodule

// File: rtl/irqr_checker.sv
module irqr_checker
  import irq_router_pkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic                    wrEn,
  input logic [1:0]              wrOp,
  input logic [IDX_W-1:0]        wrIdx,
  input logic [DATA_W-1:0]       wrData,
  input logic [NUM_BUF-1:0]      rxEvt,
  input logic [NUM_BUF-1:0]      txEvt,
  input logic [NUM_GLOB_SRC-1:0] globEvt,
  input logic [NUM_PIN-1:0]      intOutN
);
  logic noEvt;
  assign noEvt = (rxEvt == '0) && (txEvt == '0) && (globEvt == '0);

  // R1: pins are idle on the edge after reset was seen low
  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> (intOutN == '1));

  // R9: no event and no write means the pins hold
  p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && noEvt) |=> $stable(intOutN));

  // R3: without a write nothing can release an asserted pin
  p_no_release_without_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ((intOutN & ~$past(intOutN)) == '0));

  // R4: a clear with data bit 0 low has no effect
  p_zero_clear_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrOp == 2'd2 && !wrData[0] && noEvt) |=> $stable(intOutN));

  // R10: per-source writes beyond the last source have no effect
  p_bad_index_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrOp != 2'd3 && wrIdx >= IDX_W'(NUM_SRC) && noEvt) |=> $stable(intOutN));
endmodule

bind irq_router irqr_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrOp    (wrOp),
  .wrIdx   (wrIdx),
  .wrData  (wrData),
  .rxEvt   (rxEvt),
  .txEvt   (txEvt),
  .globEvt (globEvt),
  .intOutN (intOutN)
);

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrOp = '0;
  logic [6:0]  wrIdx = '0;
  logic [7:0]  wrData = '0;
  logic [31:0] rxEvt = '0;
  logic [31:0] txEvt = '0;
  logic [7:0]  globEvt = '0;
  logic [1:0]  intOutN;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_router i_irq_router (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrOp(wrOp), .wrIdx(wrIdx),
    .wrData(wrData), .rxEvt(rxEvt), .txEvt(txEvt), .globEvt(globEvt),
    .intOutN(intOutN)
  );

  // reference state, built from the requirements
  bit mPend [72];
  bit mMask [72];
  int mNode [72];
  bit mMap  [8];

  typedef struct { logic [1:0] exp; string tag; } item_t;
  item_t sbq [$];

  function automatic logic [1:0] modelPins();
    logic [1:0] p = 2'b00;
    for (int i = 0; i < 72; i++)
      if (mPend[i] && mMask[i]) p[mMap[mNode[i]]] = 1'b1;
    return ~p;
  endfunction

  task automatic drive(input string tag, input bit we, input int op, input int idx,
                       input int data, input logic [31:0] rx, input logic [31:0] tx,
                       input logic [7:0] gl);
    @(negedge clk);
    wrEn = we; wrOp = op[1:0]; wrIdx = idx[6:0]; wrData = data[7:0];
    rxEvt = rx; txEvt = tx; globEvt = gl;
    for (int i = 0; i < 72; i++) begin
      bit evt, clr;
      if (i < 64) evt = (i % 2 == 0) ? rx[i/2] : tx[i/2];
      else        evt = gl[i-64];
      clr = we && op == 2 && idx == i && data[0];
      mPend[i] = evt | (mPend[i] & !clr);
      if (we && op == 1 && idx == i) mMask[i] = data[0];
      if (we && op == 0 && idx == i) mNode[i] = data & 7;
    end
    if (we && op == 3) for (int n = 0; n < 8; n++) mMap[n] = data[n];
    @(posedge clk);
    #1;
    sbq.push_back('{modelPins(), tag});
    wrEn = 0; wrOp = '0; wrIdx = '0; wrData = '0;
    rxEvt = '0; txEvt = '0; globEvt = '0;
  endtask

  task automatic idle(input string tag);
    drive(tag, 0, 0, 0, 0, '0, '0, '0);
  endtask

  // monitor: compare each expected item half a cycle after its edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      nChecks++;
      if (intOutN !== it.exp) begin
        nFails++;
        $display("FAIL %s: intOutN=%b expected %b", it.tag, intOutN, it.exp);
      end
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run hung, expected completion");
    report();
  end

  initial begin
    for (int i = 0; i < 72; i++) begin mPend[i] = 0; mMask[i] = 0; mNode[i] = 0; end
    for (int n = 0; n < 8; n++) mMap[n] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    nChecks++;
    if (intOutN !== 2'b11) begin
      nFails++;
      $display("FAIL R1: intOutN=%b expected 11 in reset", intOutN);
    end
    rstN = 1'b1;
    idle("R1"); idle("R1");

    // R6: pending kept while disabled, appears once enabled
    drive("R6", 0, 0, 0, 0, 32'h8, '0, '0);   // rx buf 3 -> source 6
    idle("R6");
    drive("R6", 1, 1, 6, 1, '0, '0, '0);
    // R3: sticky
    idle("R3"); idle("R3"); idle("R3");
    // R4: zero-data clear ignored, then real clear
    drive("R4", 1, 2, 6, 0, '0, '0, '0);
    drive("R4", 1, 2, 6, 1, '0, '0, '0);
    // R5: clear colliding with an event
    drive("R5", 1, 2, 6, 1, 32'h8, '0, '0);
    idle("R5");
    drive("R5", 1, 2, 6, 1, '0, '0, '0);

    // R7/R8/R2: tx buf 3 is source 7, node 5, node 5 on pin 1
    drive("R7", 1, 0, 7, 5, '0, '0, '0);
    drive("R8", 1, 3, 0, 8'h20, '0, '0, '0);
    drive("R6", 1, 1, 7, 1, '0, '0, '0);
    drive("R2", 0, 0, 0, 0, '0, 32'h8, '0);
    drive("R8", 1, 3, 0, 8'h00, '0, '0, '0);

    // R2: channel 1 event 2 is source 70 on globEvt bit 6
    drive("R7", 1, 0, 70, 2, '0, '0, '0);
    drive("R6", 1, 1, 70, 1, '0, '0, '0);
    drive("R8", 1, 3, 0, 8'h04, '0, '0, '0);
    drive("R2", 0, 0, 0, 0, '0, '0, 8'h40);

    // R9: several sources OR onto one pin
    drive("R9", 1, 2, 7, 1, '0, '0, '0);
    drive("R7", 1, 0, 0, 2, '0, '0, '0);
    drive("R6", 1, 1, 0, 1, '0, '0, '0);
    drive("R9", 0, 0, 0, 0, 32'h1, '0, '0);
    drive("R9", 1, 2, 70, 1, '0, '0, '0);
    drive("R9", 1, 2, 0, 1, '0, '0, '0);

    // R10: out-of-range index writes do nothing
    drive("R6", 1, 1, 1, 1, '0, '0, '0);
    drive("R3", 0, 0, 0, 0, '0, 32'h1, '0);   // tx buf 0 -> source 1, node 0
    drive("R10", 1, 2, 100, 1, '0, '0, '0);
    drive("R10", 1, 0, 127, 3, '0, '0, '0);
    drive("R10", 1, 1, 72, 0, '0, '0, '0);
    drive("R4", 1, 2, 1, 1, '0, '0, '0);

    // R2: last buffer receive is source 62; channel 0 event 0 is source 64
    drive("R7", 1, 0, 62, 7, '0, '0, '0);
    drive("R8", 1, 3, 0, 8'h80, '0, '0, '0);
    drive("R6", 1, 1, 62, 1, '0, '0, '0);
    drive("R2", 0, 0, 0, 0, 32'h8000_0000, '0, '0);
    drive("R6", 1, 1, 64, 1, '0, '0, '0);
    drive("R2", 0, 0, 0, 0, '0, '0, 8'h01);
    drive("R9", 1, 2, 62, 1, '0, '0, '0);
    drive("R9", 1, 2, 64, 1, '0, '0, '0);
    idle("R1");

    repeat (2) @(posedge clk);
    report();
  end
endmodule